// File: doc/BRIEF.md
# Double-Buffered Grayscale PWM Channel Driver

This block turns a serial stream of per-channel brightness words into a set of pulse-width-modulated on/off outputs. A long shift register collects one word per channel from a serial data line. A strobe copies the collected words into a holding stage. A second stage feeds the comparators. A free-running grayscale counter, advanced by its own clock input, is compared against each channel's word in that second stage. A channel is on while the count is below its word.

The two stages let new data arrive while a PWM cycle is running. A strobe only fills the holding stage. The comparator stage takes the new words in two cases: at the end of a full counter cycle when auto-repeat is on, or while the blank input is high with the mode select low. Blank also turns every output off and returns the counter to zero. The serial side and the latch strobe respond only while the mode select is low.

A serial output carries the shift register's top bit, so several blocks can be chained. All the slow clocks and the strobe are sampled by one fast system clock. Each of them acts on its rising edge.

Top module: `gspwm_driver`

## Requirements
- R1: Each rising edge of `ser_clk_i` with `sel_i` low shifts `ser_data_i` into bit 0 and moves every bit up by one. Channel c holds its word in bits c*GS_BITS+GS_BITS-1 down to c*GS_BITS, with the word's MSB at the top. After NUM_CH*GS_BITS shifts, the first bit sent sits in the top bit of the highest channel.
- R2: `ser_out_o` always equals the top bit of the shift register and changes on the same system edge as a shift.
- R3: A rising edge of `strobe_i` with `sel_i` low copies the shift register into the holding stage. While the counter runs, this does not change the outputs before the current cycle ends.
- R4: While `sel_i` is high, serial-clock edges and strobe edges change neither the shift register nor the holding stage.
- R5: While `blank_i` is high and `sel_i` is low, the comparator stage loads from the holding stage. When `blank_i` is high with `sel_i` high, the comparator stage keeps its contents.
- R6: While `blank_i` is high, every output is off and the grayscale counter is held at 0.
- R7: With `blank_i` low, each rising edge of `gs_clk_i` advances the counter by one. Channel c is on exactly while the count is less than its word, so a word of 0 never turns the channel on.
- R8: With `auto_rpt_i` high, the grayscale edge that finds the count at its maximum returns the counter to 0. On that same edge the comparator stage loads from the holding stage.
- R9: With `auto_rpt_i` low, the counter stays at its maximum after the last step, so all outputs stay off until `blank_i` is pulsed.
- R10: Synchronous reset clears all registers, so every output is off and `ser_out_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples all other inputs |
| rst | input | 1 | Synchronous active-high reset |
| ser_clk_i | input | 1 | Serial shift clock, acts on its rising edge |
| ser_data_i | input | 1 | Serial data bit |
| strobe_i | input | 1 | Latch strobe, acts on its rising edge |
| sel_i | input | 1 | Mode select; low selects the grayscale path |
| gs_clk_i | input | 1 | Grayscale counter clock, acts on its rising edge |
| blank_i | input | 1 | Forces outputs off, clears the counter, and loads the comparator stage when `sel_i` is low |
| auto_rpt_i | input | 1 | Restarts the PWM cycle automatically at its end |
| ser_out_o | output | 1 | Top bit of the shift register, for chaining |
| chan_on_o | output | NUM_CH | Per-channel PWM on/off outputs |

## Verification
Shift, strobe and grayscale inputs take effect on the first system edge after their rising edge is driven. Blank takes effect on the system edge after it is raised. The outputs are combinational from the counter, the comparator stage and `blank_i`, so each result is visible right after that one edge. The bench drives every input on a falling system edge. It samples on the next falling edge, which is after exactly one rising edge, and steps a bench-side count and stage model at that moment. A small configuration of four channels with four-bit words lets the sweeps cover every word value at every count, the wrap edge and the points past the end of a cycle.

// File: rtl/gspwm_pkg.sv
package gspwm_pkg;

    // Positions of the sampled strobe-like inputs inside the edge bundle
    typedef struct packed {
        logic ser;
        logic strobe;
        logic gs;
    } edge_bundle_t;

    localparam int EDGE_W = $bits(edge_bundle_t);

    // Maximum count for a counter of the given width
    function automatic int unsigned count_top(input int unsigned bits);
        return (32'd1 << bits) - 32'd1;
    endfunction

endpackage

// File: rtl/gspwm_edge.sv
module gspwm_edge #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] sig_i,
    output logic [N-1:0] rise_o
);
    logic [N-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= sig_i;
    end

    assign rise_o = sig_i & ~prev_q;

endmodule

// File: rtl/gspwm_shift.sv
module gspwm_shift #(
    parameter int W = 256
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         shift_i,
    input  logic         din_i,
    output logic [W-1:0] sr_o,
    output logic         sout_o
);
    logic [W-1:0] sr_q;

    always_ff @(posedge clk) begin
        if (rst)          sr_q <= '0;
        else if (shift_i) sr_q <= {sr_q[W-2:0], din_i};
    end

    assign sr_o   = sr_q;
    assign sout_o = sr_q[W-1];

    assert_shift_in_R1: assert property (@(posedge clk) disable iff (rst)
        shift_i |=> (sr_q[0] == $past(din_i)) && (sr_q[W-1:1] == $past(sr_q[W-2:0])));

    assert_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !shift_i |=> $stable(sr_q));

endmodule

// File: rtl/gspwm_latch.sv
module gspwm_latch #(
    parameter int W = 256
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cap1_i,
    input  logic         load2_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] l2_o
);
    logic [W-1:0] l1_q;
    logic [W-1:0] l2_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            l1_q <= '0;
            l2_q <= '0;
        end else begin
            if (cap1_i)  l1_q <= d_i;
            if (load2_i) l2_q <= l1_q;
        end
    end

    assign l2_o = l2_q;

    assert_capture_R3: assert property (@(posedge clk) disable iff (rst)
        cap1_i |=> l1_q == $past(d_i));

    assert_transfer_R5: assert property (@(posedge clk) disable iff (rst)
        load2_i |=> l2_q == $past(l1_q));

    assert_second_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !load2_i |=> $stable(l2_q));

endmodule

// File: rtl/gspwm_pwm.sv
module gspwm_pwm
    import gspwm_pkg::*;
#(
    parameter int NUM_CH  = 16,
    parameter int GS_BITS = 16
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      blank_i,
    input  logic                      auto_i,
    input  logic                      tick_i,
    input  logic [NUM_CH*GS_BITS-1:0] data_i,
    output logic [NUM_CH-1:0]         chan_on_o,
    output logic                      wrap_o
);
    localparam logic [GS_BITS-1:0] CNT_MAX = GS_BITS'(count_top(GS_BITS));

    logic [GS_BITS-1:0] cnt_q;
    logic               at_end;

    assign at_end = (cnt_q == CNT_MAX);
    assign wrap_o = tick_i & ~blank_i & at_end & auto_i;

    always_ff @(posedge clk) begin
        if (rst || blank_i) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            if (!at_end)     cnt_q <= cnt_q + 1'b1;
            else if (auto_i) cnt_q <= '0;
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign chan_on_o[c] = ~blank_i & (cnt_q < data_i[c*GS_BITS +: GS_BITS]);
    end

    assert_blank_clear_R6: assert property (@(posedge clk) disable iff (rst)
        blank_i |=> cnt_q == '0);

    assert_step_R7: assert property (@(posedge clk) disable iff (rst)
        (tick_i && !blank_i && !at_end) |=> cnt_q == GS_BITS'($past(cnt_q) + 1'b1));

    assert_idle_R7: assert property (@(posedge clk) disable iff (rst)
        (!tick_i && !blank_i) |=> $stable(cnt_q));

    assert_wrap_R8: assert property (@(posedge clk) disable iff (rst)
        wrap_o |=> cnt_q == '0);

    assert_stop_R9: assert property (@(posedge clk) disable iff (rst)
        (tick_i && !blank_i && !auto_i && at_end) |=> cnt_q == CNT_MAX);

endmodule

// File: rtl/gspwm_driver.sv
module gspwm_driver
    import gspwm_pkg::*;
#(
    parameter int NUM_CH  = 16,
    parameter int GS_BITS = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_clk_i,
    input  logic              ser_data_i,
    input  logic              strobe_i,
    input  logic              sel_i,
    input  logic              gs_clk_i,
    input  logic              blank_i,
    input  logic              auto_rpt_i,
    output logic              ser_out_o,
    output logic [NUM_CH-1:0] chan_on_o
);
    localparam int SR_W = NUM_CH * GS_BITS;

    edge_bundle_t      raw, rise;
    logic [SR_W-1:0]   sr;
    logic [SR_W-1:0]   l2;
    logic              wrap;
    logic              load2;

    assign raw.ser    = ser_clk_i;
    assign raw.strobe = strobe_i;
    assign raw.gs     = gs_clk_i;

    gspwm_edge #(.N(EDGE_W)) i_edge (
        .clk    (clk),
        .rst    (rst),
        .sig_i  (raw),
        .rise_o (rise)
    );

    gspwm_shift #(.W(SR_W)) i_shift (
        .clk     (clk),
        .rst     (rst),
        .shift_i (rise.ser & ~sel_i),
        .din_i   (ser_data_i),
        .sr_o    (sr),
        .sout_o  (ser_out_o)
    );

    assign load2 = (blank_i & ~sel_i) | wrap;

    gspwm_latch #(.W(SR_W)) i_latch (
        .clk     (clk),
        .rst     (rst),
        .cap1_i  (rise.strobe & ~sel_i),
        .load2_i (load2),
        .d_i     (sr),
        .l2_o    (l2)
    );

    gspwm_pwm #(.NUM_CH(NUM_CH), .GS_BITS(GS_BITS)) i_pwm (
        .clk       (clk),
        .rst       (rst),
        .blank_i   (blank_i),
        .auto_i    (auto_rpt_i),
        .tick_i    (rise.gs),
        .data_i    (l2),
        .chan_on_o (chan_on_o),
        .wrap_o    (wrap)
    );

    assert_blank_off_R6: assert property (@(posedge clk) disable iff (rst)
        $past(blank_i) && blank_i |-> chan_on_o == '0);

    assert_sel_guard_R4: assert property (@(posedge clk) disable iff (rst)
        sel_i |=> $stable(ser_out_o));

    assert_reset_R10: assert property (@(posedge clk)
        $past(rst) |-> (chan_on_o == '0) && !ser_out_o);

endmodule

// File: tb/test_gspwm_driver.sv
module test_gspwm_driver;
    localparam int CH  = 4;
    localparam int B   = 4;
    localparam int W   = CH * B;
    localparam int MAX = (1 << B) - 1;

    logic clk = 0, rst = 1;
    logic ser_clk = 0, ser_data = 0, strobe = 0, sel = 0, gs_clk = 0, blank = 0, auto_rpt = 0;
    logic ser_out;
    logic [CH-1:0] chan_on;

    int errs = 0, checks = 0;
    logic [W-1:0] m_sr = '0, m_l1 = '0, m_l2 = '0;
    int cnt_m = 0;

    always #10 clk = ~clk;

    gspwm_driver #(.NUM_CH(CH), .GS_BITS(B)) i_gspwm_driver (
        .clk(clk), .rst(rst), .ser_clk_i(ser_clk), .ser_data_i(ser_data),
        .strobe_i(strobe), .sel_i(sel), .gs_clk_i(gs_clk), .blank_i(blank),
        .auto_rpt_i(auto_rpt), .ser_out_o(ser_out), .chan_on_o(chan_on));

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errs++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [CH-1:0] exp_out();
        logic [CH-1:0] e;
        for (int c = 0; c < CH; c++) e[c] = (cnt_m < int'(m_l2[c*B +: B]));
        return e;
    endfunction

    task automatic check_out(input string req);
        logic [CH-1:0] e;
        e = blank ? '0 : exp_out();
        chk(chan_on === e, req, int'(chan_on), int'(e));
    endtask

    task automatic shift_bit(input logic d);
        ser_data = d; ser_clk = 1;
        @(negedge clk);
        ser_clk = 0;
        @(negedge clk);
        if (!sel) m_sr = {m_sr[W-2:0], d};
        chk(ser_out === m_sr[W-1], "R2", int'(ser_out), int'(m_sr[W-1]));
    endtask

    task automatic load_word(input logic [W-1:0] w);
        for (int i = W - 1; i >= 0; i--) shift_bit(w[i]);
    endtask

    task automatic do_strobe();
        strobe = 1;
        @(negedge clk);
        strobe = 0;
        @(negedge clk);
        if (!sel) m_l1 = m_sr;
    endtask

    task automatic blank_pulse();
        blank = 1;
        @(negedge clk);
        if (!sel) m_l2 = m_l1;
        cnt_m = 0;
        chk(chan_on === '0, "R6", int'(chan_on), 0);
        blank = 0;
        @(negedge clk);
    endtask

    task automatic gs_tick();
        gs_clk = 1;
        @(negedge clk);
        gs_clk = 0;
        @(negedge clk);
        if (cnt_m == MAX) begin
            if (auto_rpt) begin
                cnt_m = 0;
                m_l2 = m_l1;
            end
        end else begin
            cnt_m++;
        end
    endtask

    function automatic logic [W-1:0] make_word(input int s);
        logic [W-1:0] w;
        for (int c = 0; c < CH; c++) w[c*B +: B] = B'((s * CH + c) * 7);
        return w;
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        errs++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R10: reset state
        chk(chan_on === '0, "R10", int'(chan_on), 0);
        chk(ser_out === 1'b0, "R10", int'(ser_out), 0);

        // R1/R7/R9: every word value at every count, no auto-repeat
        auto_rpt = 0;
        for (int s = 0; s < 4; s++) begin
            load_word(make_word(s));
            do_strobe();
            blank_pulse();
            check_out("R1");
            for (int k = 1; k <= MAX; k++) begin
                gs_tick();
                check_out("R7");
            end
            for (int k = 0; k < 3; k++) begin
                gs_tick();
                check_out("R9");
                chk(chan_on === '0, "R9", int'(chan_on), 0);
            end
        end

        // R3/R8: double buffering with auto-repeat
        auto_rpt = 1;
        load_word(16'hF95A);
        do_strobe();
        blank_pulse();
        check_out("R3");
        for (int k = 0; k < 5; k++) gs_tick();
        load_word(16'h3C81);
        do_strobe();
        for (int k = cnt_m; k < MAX; k++) begin
            gs_tick();
            check_out("R3");
        end
        gs_tick();
        chk(cnt_m == 0, "R8", cnt_m, 0);
        check_out("R8");
        for (int k = 0; k < 6; k++) begin
            gs_tick();
            check_out("R8");
        end

        // R6: blank mid-cycle forces off and restarts at 0
        blank_pulse();
        check_out("R6");

        // R4: select high ignores shifts and strobes
        sel = 1;
        load_word(16'h0000);
        do_strobe();
        sel = 0;
        blank_pulse();
        check_out("R4");
        gs_tick();
        check_out("R4");

        // R5: blank with select high keeps the comparator stage
        load_word(16'h7E24);
        do_strobe();
        sel = 1;
        blank_pulse();
        sel = 0;
        check_out("R5");
        gs_tick();
        check_out("R5");
        blank_pulse();
        check_out("R5");
        for (int k = 0; k < 4; k++) begin
            gs_tick();
            check_out("R5");
        end

        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule